// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial configuration EEPROM on behalf of a host controller. The host raises a one-cycle start pulse together with a word address and a word count. For each word, the block selects the device, shifts out an 11-bit frame that merges the read opcode with the address, and clocks in 16 data bits. It then presents the word on a parallel output with a one-cycle valid strobe. After each word the serial pins return to their inactive level.

A burst of several words reads ascending addresses. Chip select goes low between words, so the device sees a separate read for each one. A typical use is reading three words from address zero at boot to recover a 48-bit station address.

The serial clock comes from a divider of the system clock, so each half period lasts a parameterised number of cycles. A second parameter sets the minimum chip-select-low time that comes before every selection.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `word_valid_o`, `cs_o`, `rom_sel_o`, `sk_o` and `di_o` are all low.
- R2: Every word read sends an 11-bit frame, most significant bit first, with one bit per rising edge of `sk_o`. Frame bits 10..8 carry the read opcode 3'b110 and bits 7..0 carry the word address.
- R3: `di_o` changes only while `sk_o` is low. It holds its value from the cycle before each rising edge of `sk_o` to the end of that high phase.
- R4: After the frame, 16 data bits are taken from `do_i` during 16 high phases of `sk_o`, most significant bit first. The word then appears on `word_o` with `word_valid_o` high for exactly one cycle.
- R5: Each high phase of `sk_o` lasts exactly HALF_DIV clock cycles (default 2). Each low phase lasts at least HALF_DIV cycles.
- R6: In the cycle `word_valid_o` is high, `cs_o`, `rom_sel_o`, `sk_o` and `di_o` are all low. Every rise of `cs_o` follows at least CS_GAP consecutive low cycles (default 4).
- R7: A request for N words reads N consecutive addresses starting at `addr_i`, wrapping modulo 256. The words are returned in address order.
- R8: `busy_o` is high from the cycle after an accepted start up to and including the cycle of the last valid strobe. It is low in the following cycle.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running burst keeps its address and count, and no extra words appear.
- R10: A start pulse with `count_i` equal to 0 is ignored: `busy_o` stays low and no word is read.
- R11: `rom_sel_o` and `cs_o` are asserted and released together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| addr_i | input | 8 | First word address of the request |
| count_i | input | 8 | Number of words to read |
| busy_o | output | 1 | Request in progress |
| word_o | output | 16 | Word read from the device |
| word_valid_o | output | 1 | One-cycle strobe marking `word_o` valid |
| rom_sel_o | output | 1 | EEPROM access enable, follows chip select |
| cs_o | output | 1 | Device chip select, active high |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data towards the device |
| do_i | input | 1 | Serial data from the device |

## Verification
A wrong sequencer state shows up at the serial pins within one half period of `sk_o`. It appears as a frame of the wrong length, a high phase of the wrong width, or data moving under a high clock. A model of the device on the bench decodes each frame, so an address or opcode error gives a wrong word at the very next valid strobe. A wrong burst counter shows as a missing or extra strobe, or as `busy_o` falling at the wrong time around the final word. A chip select that fails to drop between words makes the model lose frame alignment, and every later word is corrupted.

// File: rtl/ee_rd_pkg.sv
// Package: shared state encoding and constants for the serial EEPROM reader.
// Assumes: one data word width for every device this block talks to.
package ee_rd_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GAP,
        S_SETUP,
        S_CMD_LO,
        S_CMD_HI,
        S_MID,
        S_RD_HI,
        S_RD_LO,
        S_END
    } ee_state_e;

endpackage

// File: rtl/ee_phase_timer.sv
// Phase timer: counts system cycles inside one sequencer phase and flags the
// last cycle of the phase. Assumes len_i >= 1 and that clr_i or done_o
// restarts the count whenever the phase changes.
module ee_phase_timer #(
    parameter int MAX_LEN = 4,
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [LW-1:0] len_i,
    output logic          done_o
);
    logic [LW-1:0] cnt_q;

    // Last cycle of the phase.
    assign done_o = ((cnt_q + 1'b1) == len_i);

    // Cycle counter, restarted at every phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr_i || done_o) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    // The count never runs past the phase length (R5 timing base).
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_i);
endmodule

// File: rtl/ee_frame_shifter.sv
// Frame shifter: holds the outgoing command/address frame and presents its
// most significant bit. Assumes load and shift are never requested together.
module ee_frame_shifter #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               msb_o
);
    logic [FRAME_W-1:0] sr_q;

    assign msb_o = sr_q[FRAME_W-1];

    // Load a new frame or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= frame_i;
        else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end
endmodule

// File: rtl/ee_word_capture.sv
// Word capture: gathers serial data bits, most significant bit first.
// Assumes exactly WORD_W samples per word; older bits fall off the top.
module ee_word_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o
);
    // Shift one sampled bit into the bottom of the word.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (sample_i) word_o <= {word_o[WORD_W-2:0], din_i};
    end
endmodule

// File: rtl/ee_seq.sv
// Sequencer: walks each word read through gap, select, command, turnaround,
// data and end phases, and tracks the burst address and remaining count.
// Assumes done_i marks the last cycle of the current phase and that the
// timer restarts on every phase change.
module ee_seq
    import ee_rd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 8,
    parameter int FRAME_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              done_i,
    output logic              tmr_clr_o,
    output logic              gap_phase_o,
    output logic              frm_load_o,
    output logic              frm_shift_o,
    output logic              cap_sample_o,
    output logic              sel_o,
    output logic              sk_o,
    output logic              di_from_frame_o,
    output logic              valid_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int MAXB = (FRAME_W > WORD_W) ? FRAME_W : WORD_W;
    localparam int BW   = $clog2(MAXB) + 1;

    ee_state_e         st_q, st_d;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] adr_q;
    logic [BW-1:0]     bit_q;
    logic              last_cmd, last_rd;

    assign last_cmd = (bit_q == BW'(FRAME_W - 1));
    assign last_rd  = (bit_q == BW'(WORD_W - 1));

    // Next-state choice, driven by the phase timer.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_i && (count_i != '0)) st_d = S_GAP;
            S_GAP:    if (done_i) st_d = S_SETUP;
            S_SETUP:  if (done_i) st_d = S_CMD_LO;
            S_CMD_LO: if (done_i) st_d = S_CMD_HI;
            S_CMD_HI: if (done_i) st_d = last_cmd ? S_MID : S_CMD_LO;
            S_MID:    if (done_i) st_d = S_RD_HI;
            S_RD_HI:  if (done_i) st_d = S_RD_LO;
            S_RD_LO:  if (done_i) st_d = last_rd ? S_END : S_RD_HI;
            S_END:    st_d = (left_q == CNT_W'(1)) ? S_IDLE : S_GAP;
            default:  st_d = S_IDLE;
        endcase
    end

    // State, burst address and remaining word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            left_q <= '0;
            adr_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && st_d == S_GAP) begin
                left_q <= count_i;
                adr_q  <= addr_i;
            end else if (st_q == S_END && st_d == S_GAP) begin
                left_q <= left_q - 1'b1;
                adr_q  <= adr_q + 1'b1;
            end
        end
    end

    // Bit counter for the command and data phases.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= '0;
        else if (st_q == S_SETUP || st_q == S_MID)
            bit_q <= '0;
        else if ((st_q == S_CMD_HI || st_q == S_RD_LO) && done_i)
            bit_q <= bit_q + 1'b1;
    end

    // Phase decode of controls and pin levels.
    always_comb begin
        tmr_clr_o       = (st_q == S_IDLE) || (st_q == S_END);
        gap_phase_o     = (st_q == S_GAP);
        frm_load_o      = (st_q == S_GAP) && done_i;
        frm_shift_o     = (st_q == S_CMD_HI) && done_i;
        cap_sample_o    = (st_q == S_RD_HI) && done_i;
        sel_o           = (st_q == S_SETUP) || (st_q == S_CMD_LO) ||
                          (st_q == S_CMD_HI) || (st_q == S_MID) ||
                          (st_q == S_RD_HI) || (st_q == S_RD_LO);
        sk_o            = (st_q == S_CMD_HI) || (st_q == S_RD_HI);
        di_from_frame_o = (st_q == S_CMD_LO) || (st_q == S_CMD_HI);
        valid_o         = (st_q == S_END);
        busy_o          = (st_q != S_IDLE);
    end

    assign addr_o = adr_q;

    // No more than FRAME_W command bits are sent per word (R2).
    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CMD_LO || st_q == S_CMD_HI) |-> (bit_q < BW'(FRAME_W)));

    // A start while busy leaves the burst untouched (R9).
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q != S_IDLE && st_q != S_END)
        |=> ($stable(left_q) && $stable(adr_q)));

    // A zero-length request is not accepted (R10).
    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && start_i && count_i == '0) |=> !busy_o);

    // Busy drops right after the final strobe (R8).
    p_burst_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && left_q == CNT_W'(1)) |=> !busy_o);
endmodule

// File: rtl/ee_word_reader.sv
// Serial EEPROM word reader top: ties the phase timer, frame shifter, word
// capture and sequencer together and forms the command frame.
// Assumes: the device shifts data out on rising serial clock edges and
// holds each bit through the following high phase.
module ee_word_reader #(
    parameter int              ADDR_W   = 8,
    parameter int              OPC_W    = 3,
    parameter logic [OPC_W-1:0] RD_OPC  = 3'b110,
    parameter int              CNT_W    = 8,
    parameter int              HALF_DIV = 2,
    parameter int              CS_GAP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic [15:0]       word_o,
    output logic              word_valid_o,
    output logic              rom_sel_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int FRAME_W = OPC_W + ADDR_W;
    localparam int TMAX    = (HALF_DIV > CS_GAP) ? HALF_DIV : CS_GAP;
    localparam int LW      = $clog2(TMAX + 1);

    logic              done, tmr_clr, gap_phase, frm_load, frm_shift;
    logic              cap_sample, sel, di_frame, frm_msb;
    logic [ADDR_W-1:0] cur_addr;
    logic [FRAME_W-1:0] frame;
    logic [LW-1:0]     phase_len;

    // Opcode merged above the word address.
    assign frame     = (FRAME_W'(RD_OPC) << ADDR_W) | FRAME_W'(cur_addr);
    assign phase_len = gap_phase ? LW'(CS_GAP) : LW'(HALF_DIV);

    ee_phase_timer #(.MAX_LEN(TMAX)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .len_i(phase_len), .done_o(done)
    );

    ee_frame_shifter #(.FRAME_W(FRAME_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .load_i(frm_load), .frame_i(frame),
        .shift_i(frm_shift), .msb_o(frm_msb)
    );

    ee_word_capture #(.WORD_W(16)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample_i(cap_sample),
        .din_i(do_i), .word_o(word_o)
    );

    ee_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .count_i(count_i), .done_i(done), .tmr_clr_o(tmr_clr),
        .gap_phase_o(gap_phase), .frm_load_o(frm_load),
        .frm_shift_o(frm_shift), .cap_sample_o(cap_sample), .sel_o(sel),
        .sk_o(sk_o), .di_from_frame_o(di_frame), .valid_o(word_valid_o),
        .busy_o(busy_o), .addr_o(cur_addr)
    );

    assign cs_o      = sel;
    assign rom_sel_o = sel;
    assign di_o      = di_frame & frm_msb;

    // Data towards the device is settled before the clock rises (R3).
    p_di_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_o) |-> $stable(di_o));

    // All serial pins are released when a word is handed over (R6).
    p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (!cs_o && !sk_o && !di_o));
endmodule

// File: tb/ee_word_reader_tb.sv
// Scoreboard bench: a driver task queues the expected words, a device model
// answers frames on the serial pins, and a monitor compares every strobe.
module ee_word_reader_tb;
    localparam int HALF = 2;
    localparam int GAP  = 4;
    localparam int FW   = 11;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ee_do = 1'b0;
    logic [7:0] addr = '0, count = '0;
    logic busy_o, word_valid_o, rom_sel_o, cs_o, sk_o, di_o;
    logic [15:0] word_o;

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    ee_word_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .count_i(count), .busy_o(busy_o), .word_o(word_o),
        .word_valid_o(word_valid_o), .rom_sel_o(rom_sel_o), .cs_o(cs_o),
        .sk_o(sk_o), .di_o(di_o), .do_i(ee_do)
    );

    function automatic logic [15:0] memf(input logic [7:0] a);
        return (16'(a) * 16'h9E37) ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor, pin checker and device model, all sampled at the falling edge.
    int hi_len = 0, lo_len = 0, cs_lo = 1000, mcnt = 0;
    logic sk_p = 0, cs_p = 0, di_p = 0, pend_busy = 0;
    logic [FW-1:0] mrx = '0;
    logic [15:0] mtx = '0, got;
    always @(negedge clk) begin
        if (rst_n) begin
            // R5 clock phase widths, R3 data stable while clock high, R11
            if (sk_o && !sk_p) begin
                check(lo_len >= HALF, "R5 low phase", lo_len, HALF);
                check(rom_sel_o == cs_o && cs_o, "R11 select pair", rom_sel_o, cs_o);
                lo_len = 0;
            end
            if (!sk_o && sk_p) begin
                check(hi_len == HALF, "R5 high phase", hi_len, HALF);
                hi_len = 0;
            end
            if (sk_o) begin
                hi_len++;
                check(di_o == di_p, "R3 di stable", di_o, di_p);
            end else lo_len++;
            // R6 chip select gap
            if (cs_o && !cs_p) check(cs_lo >= GAP, "R6 cs gap", cs_lo, GAP);
            if (cs_o) cs_lo = 0; else cs_lo++;
            // Device model: decodes the R2 frame, replies MSB first (R4)
            if (!cs_o) mcnt = 0;
            else if (sk_o && !sk_p) begin
                if (mcnt < FW) begin
                    mrx = {mrx[FW-2:0], di_o};
                    mcnt++;
                    if (mcnt == FW)
                        mtx = (mrx[FW-1:8] == 3'b110) ? memf(mrx[7:0]) : ~memf(mrx[7:0]);
                end else begin
                    ee_do = mtx[15];
                    mtx = {mtx[14:0], 1'b0};
                    mcnt++;
                end
            end
            // R8 busy falls right after the last strobe
            if (pend_busy) begin
                check(!busy_o, "R8 busy after last word", busy_o, 0);
                pend_busy = 0;
            end
            // Scoreboard
            if (word_valid_o) begin
                check(!cs_o && !rom_sel_o && !sk_o && !di_o, "R6 quiet at valid",
                      {cs_o, rom_sel_o, sk_o, di_o}, 0);
                if (exp_q.size() == 0) check(0, "R9 unexpected word", word_o, 0);
                else begin
                    got = exp_q.pop_front();
                    check(word_o == got, "R4/R7 word", word_o, got);
                    if (exp_q.size() == 0) pend_busy = 1;
                end
            end
            sk_p = sk_o; cs_p = cs_o; di_p = di_o;
        end
    end

    // Driver: queue expected words (when accepted) and pulse start.
    task automatic request(input logic [7:0] a, input logic [7:0] n, input bit accept);
        @(negedge clk);
        if (accept)
            for (int i = 0; i < n; i++) exp_q.push_back(memf(8'(a + i)));
        start = 1'b1; addr = a; count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check({busy_o, word_valid_o, cs_o, rom_sel_o, sk_o, di_o} == 6'b0,
              "R1 outputs in reset", {busy_o, word_valid_o, cs_o, rom_sel_o, sk_o, di_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy_o, word_valid_o, cs_o, rom_sel_o, sk_o, di_o} == 6'b0,
              "R1 outputs after reset", {busy_o, word_valid_o, cs_o, rom_sel_o, sk_o, di_o}, 0);

        // R7 station address: three words from address zero
        request(8'h00, 8'd3, 1);
        check(busy_o, "R8 busy after start", busy_o, 1);
        wait_idle();
        // R2 single word at a mixed-bit address
        request(8'h5C, 8'd1, 1);
        wait_idle();
        // R7 burst wrapping past the top address
        request(8'hFE, 8'd3, 1);
        wait_idle();
        // R9 start during a burst is ignored
        request(8'h10, 8'd4, 1);
        repeat (150) @(negedge clk);
        check(busy_o, "R9 burst running", busy_o, 1);
        request(8'h77, 8'd2, 0);
        wait_idle();
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        // R10 zero count ignored
        request(8'h20, 8'd0, 0);
        check(!busy_o, "R10 zero count", busy_o, 0);
        repeat (200) @(negedge clk);
        check(!busy_o && !cs_o, "R10 stays idle", {busy_o, cs_o}, 0);
        check(exp_q.size() == 0, "R7 all words seen", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule